// File: doc/BRIEF.md
# Store Write Coalescing Buffer

This block sits between a processor core that issues 32-bit word stores and a memory bus that is 64 bits wide. A core store carries a word address, a data word, per-byte enables and a page attribute saying whether the store may be merged. A double-word store reaches the block as two stores to neighbouring word addresses. Merging needs two things. The global disable input must be low, and the store's page attribute must permit it. A store that may be merged goes into a small fully associative buffer of doubleword entries. There it merges with any earlier store to the same 64-bit aligned doubleword. Each entry later leaves as one 64-bit bus write whose byte enables are the union of the merged stores.

A store that may not be merged first waits until every buffered entry has left. It then goes out alone as a 32-bit bus transaction, so traffic that cannot be merged keeps program order. Merged entries may leave in any order. A fence request is the only ordering tool for them. After a fence, no new store is taken until the buffer and the bus output register are both empty. A one-cycle completion pulse then marks the end of the fence.

Top module: `store_coalesce_buf`

## Requirements
- R1: After synchronous reset, `bus_valid` and `fence_done` are low, and an idle store port with merging allowed shows `st_ready` high.
- R2: While `coal_off` is 1, every accepted store leaves as its own narrow transaction: `bus_wide`=0, `bus_addr` = word address with the two low bits zero, store bytes in `bus_data[31:0]`, store enables in `bus_be[3:0]`, and zero in the upper half of data and enables.
- R3: While `coal_off` is 0, a store with `st_permit`=0 still leaves as a narrow transaction in the R2 format and is never merged.
- R4: Mergeable stores to one doubleword form one wide transaction (`bus_wide`=1). `bus_addr` has its three low bits zero. Word address bit 0 = 0 selects lanes [31:0]/enables [3:0], and 1 selects lanes [63:32]/enables [7:4]. A later store to an already-enabled byte overwrites it. No two valid entries ever hold the same doubleword.
- R5: An entry whose eight byte enables are all set leaves without any fence. On every transaction, data bytes whose enable is 0 read as zero.
- R6: A non-mergeable store is held off until all buffered entries have left. It reaches the bus after them.
- R7: When all entries are occupied, the lowest-numbered entry is drained. A store to a new doubleword is accepted once that entry is free.
- R8: From the cycle after `fence_req` until `fence_done`, `st_ready` is low. `fence_done` is a one-cycle pulse raised only when the buffer and the bus output are empty. A store handshaken in the same cycle as `fence_req` counts as older and leaves before the pulse.
- R9: A fence raised on an empty block produces `fence_done` at the second clock edge after the request.
- R10: `fence_req` seen while a fence is already pending is ignored and gives no extra `fence_done` pulse.
- R11: While `bus_valid` is high and `bus_ready` low, the bus payload holds still, and no transaction is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coal_off | input | 1 | Global merge disable, 1 = never merge |
| st_valid | input | 1 | Core store valid |
| st_ready | output | 1 | Core store accepted when high with st_valid |
| st_waddr | input | ADDR_W-2 | Store word address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| st_permit | input | 1 | Page attribute allowing merge |
| fence_req | input | 1 | Fence request |
| fence_done | output | 1 | One-cycle fence completion pulse |
| bus_valid | output | 1 | Bus write valid |
| bus_ready | input | 1 | Bus accepts write |
| bus_wide | output | 1 | 1 = 64-bit write, 0 = 32-bit write |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_data | output | 64 | Bus write data |
| bus_be | output | 8 | Bus byte enables |

## Verification
The case that matters most is a fence request and a store handshake in the same cycle. The bench raises `fence_req` in the very cycle it presents a partial mergeable store. It then checks four things: the store is taken in that cycle; `st_ready` drops on the next cycle; the doubleword reaches the bus; and the scoreboard queue is empty when `fence_done` pulses. The same-cycle case of an entry leaving while a new store to a different doubleword waits for a free slot is also covered. The bench checks the resulting bus order against the lowest-entry-first rule.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic {
    XFER_NARROW = 1'b0,
    XFER_WIDE   = 1'b1
  } xfer_kind_e;
endpackage

// File: rtl/scb_entry_file.sv
module scb_entry_file #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 29,
  parameter int DW      = 64,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DW-1:0]      wr_data,
  input  logic [DW/8-1:0]    wr_be,
  input  logic               drain_en,
  input  logic [IDX_W-1:0]   drain_idx,
  output logic               hit,
  output logic               free_avail,
  output logic               empty,
  output logic [ENTRIES-1:0] vld_vec,
  output logic [ENTRIES-1:0] full_vec,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DW-1:0]      rd_data,
  output logic [DW/8-1:0]    rd_be
);
  localparam int DBE = DW / 8;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [DW-1:0]      dat_q [ENTRIES];
  logic [DBE-1:0]     be_q  [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx, tgt_idx;

  // an entry leaving this cycle cannot take a merge
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign hit_vec[gi]  = vld_q[gi] && (tag_q[gi] == wr_tag) &&
                          !(drain_en && drain_idx == IDX_W'(gi));
    assign full_vec[gi] = vld_q[gi] && (&be_q[gi]);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!vld_q[i])  free_idx = IDX_W'(i);
    end
  end

  assign hit        = |hit_vec;
  assign free_avail = ~&vld_q;
  assign empty      = ~|vld_q;
  assign tgt_idx    = hit ? hit_idx : free_idx;
  assign vld_vec    = vld_q;
  assign rd_tag     = tag_q[drain_idx];
  assign rd_data    = dat_q[drain_idx];
  assign rd_be      = be_q[drain_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (drain_en && drain_idx == IDX_W'(i)) vld_q[i] <= 1'b0;
        if (wr_en && tgt_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= wr_tag;
          if (hit) begin
            be_q[i] <= be_q[i] | wr_be;
            for (int b = 0; b < DBE; b++)
              if (wr_be[b]) dat_q[i][b*8 +: 8] <= wr_data[b*8 +: 8];
          end else begin
            be_q[i]  <= wr_be;
            dat_q[i] <= wr_data;
          end
        end
      end
    end
  end

  logic dup_any;
  always_comb begin
    dup_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (vld_q[i] && vld_q[j] && tag_q[i] == tag_q[j]) dup_any = 1'b1;
  end

  assert_unique_tags_R4: assert property (@(posedge clk) disable iff (rst) !dup_any)
    else $error("two valid entries share a doubleword tag");
endmodule

// File: rtl/scb_drain_pick.sv
module scb_drain_pick #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0] req_vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (req_vec[i]) idx = IDX_W'(i);
  end
  assign any = |req_vec;
endmodule

// File: rtl/scb_bus_out.sv
module scb_bus_out #(
  parameter int ADDR_W = 32,
  parameter int DW     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ld_wide,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DW-1:0]     ld_data,
  input  logic [DW/8-1:0]   ld_be,
  input  logic              bus_ready,
  output logic              out_free,
  output logic              bus_valid,
  output logic              bus_wide,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_data,
  output logic [DW/8-1:0]   bus_be
);
  assign out_free = !bus_valid || bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_wide  <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
      bus_be    <= '0;
    end else if (out_free) begin
      bus_valid <= load;
      if (load) begin
        bus_wide <= ld_wide;
        bus_addr <= ld_addr;
        bus_data <= ld_data;
        bus_be   <= ld_be;
      end
    end
  end

  assert_hold_payload_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data) &&
                                   $stable(bus_be) && $stable(bus_wide)))
    else $error("bus payload moved under backpressure");
endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int ENTRIES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  coal_off,
  input  logic                                  st_valid,
  output logic                                  st_ready,
  input  logic [ADDR_W-$clog2(WORD_W/8)-1:0]    st_waddr,
  input  logic [WORD_W-1:0]                     st_data,
  input  logic [WORD_W/8-1:0]                   st_be,
  input  logic                                  st_permit,
  input  logic                                  fence_req,
  output logic                                  fence_done,
  output logic                                  bus_valid,
  input  logic                                  bus_ready,
  output logic                                  bus_wide,
  output logic [ADDR_W-1:0]                     bus_addr,
  output logic [2*WORD_W-1:0]                   bus_data,
  output logic [WORD_W/4-1:0]                   bus_be
);
  import scb_pkg::*;

  localparam int WBE     = WORD_W / 8;
  localparam int DW      = 2 * WORD_W;
  localparam int DBE     = 2 * WBE;
  localparam int WOFF    = $clog2(WBE);
  localparam int DOFF    = WOFF + 1;
  localparam int WADDR_W = ADDR_W - WOFF;
  localparam int TAG_W   = ADDR_W - DOFF;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [TAG_W-1:0]   st_tag;
  logic               st_hi, st_coal, acc, wr_en, nar_ld;
  logic [WORD_W-1:0]  st_masked;
  logic [DW-1:0]      wide_data;
  logic [DBE-1:0]     wide_be;
  logic               hit, free_avail, ent_empty;
  logic [ENTRIES-1:0] vld_vec, full_vec, req_vec;
  logic [TAG_W-1:0]   rd_tag;
  logic [DW-1:0]      rd_data;
  logic [DBE-1:0]     rd_be;
  logic               drain_any, drain_en, drain_force, out_free, fence_pend;
  logic [IDX_W-1:0]   drain_idx;
  xfer_kind_e         ld_kind;
  logic [ADDR_W-1:0]  ld_addr;
  logic [DW-1:0]      ld_data;
  logic [DBE-1:0]     ld_be;

  assign st_tag  = st_waddr[WADDR_W-1:1];
  assign st_hi   = st_waddr[0];
  assign st_coal = !coal_off && st_permit;

  always_comb begin
    for (int b = 0; b < WBE; b++)
      st_masked[b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8] : 8'h00;
  end

  assign wide_data = st_hi ? {st_masked, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, st_masked};
  assign wide_be   = st_hi ? {st_be, {WBE{1'b0}}}       : {{WBE{1'b0}}, st_be};

  // store port acceptance
  assign st_ready = !fence_pend && (st_coal ? (hit || free_avail) : (ent_empty && out_free));
  assign acc      = st_valid && st_ready;
  assign wr_en    = acc && st_coal;
  assign nar_ld   = acc && !st_coal;

  // drain policy: complete entries always, everything under pressure
  assign drain_force = fence_pend || (st_valid && !st_coal) || !free_avail;
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_req
    assign req_vec[gi] = vld_vec[gi] && (full_vec[gi] || drain_force);
  end
  assign drain_en = drain_any && out_free;

  scb_entry_file #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DW(DW), .IDX_W(IDX_W)) u_entries (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tag(st_tag), .wr_data(wide_data), .wr_be(wide_be),
    .drain_en(drain_en), .drain_idx(drain_idx), .hit(hit), .free_avail(free_avail),
    .empty(ent_empty), .vld_vec(vld_vec), .full_vec(full_vec),
    .rd_tag(rd_tag), .rd_data(rd_data), .rd_be(rd_be)
  );

  scb_drain_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .req_vec(req_vec), .any(drain_any), .idx(drain_idx)
  );

  assign ld_kind = drain_en ? XFER_WIDE : XFER_NARROW;
  assign ld_addr = drain_en ? {rd_tag, {DOFF{1'b0}}} : {st_waddr, {WOFF{1'b0}}};
  assign ld_data = drain_en ? rd_data : {{WORD_W{1'b0}}, st_masked};
  assign ld_be   = drain_en ? rd_be   : {{WBE{1'b0}}, st_be};

  scb_bus_out #(.ADDR_W(ADDR_W), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .load(drain_en || nar_ld), .ld_wide(ld_kind),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_be(ld_be), .bus_ready(bus_ready),
    .out_free(out_free), .bus_valid(bus_valid), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be)
  );

  // fence tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      fence_pend <= 1'b0;
      fence_done <= 1'b0;
    end else begin
      fence_done <= 1'b0;
      if (fence_pend) begin
        if (ent_empty && !bus_valid) begin
          fence_pend <= 1'b0;
          fence_done <= 1'b1;
        end
      end else if (fence_req) begin
        fence_pend <= 1'b1;
      end
    end
  end

  assert_narrow_upper_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_wide) |-> (bus_be[DBE-1:WBE] == '0 && bus_data[DW-1:WORD_W] == '0))
    else $error("narrow transaction uses upper lanes");

  assert_uncoal_goes_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && !(st_permit && !coal_off)) |=> (bus_valid && !bus_wide))
    else $error("non-mergeable store did not leave as narrow");

  assert_fence_done_clean_R8: assert property (@(posedge clk) disable iff (rst)
    fence_done |-> (ent_empty && !bus_valid))
    else $error("fence completed with traffic pending");

  assert_fence_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fence_done |=> !fence_done)
    else $error("fence_done longer than one cycle");

  assert_wide_has_bytes_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_wide) |-> (bus_be != '0))
    else $error("wide transaction with no enables");
endmodule

// File: tb/store_coalesce_buf_bench.sv
`timescale 1ns/1ps
module store_coalesce_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coal_off = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [29:0] st_waddr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_permit = 1'b1;
  logic        fence_req = 1'b0;
  logic        fence_done;
  logic        bus_valid;
  logic        bus_ready = 1'b1;
  logic        bus_wide;
  logic [31:0] bus_addr;
  logic [63:0] bus_data;
  logic [7:0]  bus_be;

  store_coalesce_buf u_store_coalesce_buf (
    .clk(clk), .rst(rst), .coal_off(coal_off), .st_valid(st_valid), .st_ready(st_ready),
    .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be), .st_permit(st_permit),
    .fence_req(fence_req), .fence_done(fence_done), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_be(bus_be)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic        wide;
    logic [31:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   done_cnt = 0;
  bit   bp_mode = 1'b0;
  int   cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask32(input logic [31:0] d, input logic [3:0] be);
    for (int b = 0; b < 4; b++) if (!be[b]) d[b*8 +: 8] = 8'h00;
    return d;
  endfunction

  task automatic push_narrow(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                             input string req);
    q.push_back('{1'b0, {a[31:2], 2'b00}, {32'h0, mask32(d, be)}, {4'h0, be}, req});
  endtask

  task automatic push_wide(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                           input string req);
    q.push_back('{1'b1, {a[31:3], 3'b000}, d, be, req});
  endtask

  // bus ready generation, changed just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_ready <= bp_mode ? (cyc % 3 == 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_valid && bus_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected transaction", {bus_wide, bus_addr, bus_data, bus_be}, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({bus_wide, bus_addr, bus_data, bus_be} == {e.wide, e.addr, e.data, e.be}, e.req,
              "bus transaction {wide,addr,data,be}",
              {bus_wide, bus_addr, bus_data, bus_be}, {e.wide, e.addr, e.data, e.be});
      end
    end
  end

  // backpressure stability monitor (R11)
  logic         held = 1'b0;
  logic [104:0] saved = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (held)
        check({bus_valid, bus_wide, bus_addr, bus_data, bus_be} == {1'b1, saved}, "R11",
              "payload under backpressure", {bus_wide, bus_addr, bus_data, bus_be}, saved);
      held  = bus_valid && !bus_ready;
      saved = {bus_wide, bus_addr, bus_data, bus_be};
    end
  end

  always @(negedge clk) if (!rst && fence_done) done_cnt++;

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                       input bit permit);
    bit rdy;
    @(negedge clk);
    st_valid = 1'b1; st_waddr = a[31:2]; st_data = d; st_be = be; st_permit = permit;
    do begin
      #0.5;
      rdy = st_ready;
      @(posedge clk);
    end while (!rdy);
  endtask

  task automatic idle();
    @(negedge clk);
    st_valid = 1'b0; st_permit = 1'b1; fence_req = 1'b0;
  endtask

  task automatic fence(input bit with_store, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, output int waitc);
    @(negedge clk);
    fence_req = 1'b1;
    if (with_store) begin
      st_valid = 1'b1; st_waddr = a[31:2]; st_data = d; st_be = be; st_permit = 1'b1;
      #0.5;
      check(st_ready == 1'b1, "R8", "store taken alongside fence", st_ready, 1);
    end else begin
      st_valid = 1'b0;
    end
    @(negedge clk);
    fence_req = 1'b0; st_valid = 1'b0; st_permit = 1'b1;
    waitc = 1;
    if (!fence_done)
      check(st_ready == 1'b0, "R8", "st_ready low while fence pending", st_ready, 0);
    while (!fence_done && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    check(fence_done == 1'b1, "R8", "fence completed", fence_done, 1);
    check(q.size() == 0, "R8", "older traffic drained at fence_done", q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int w;
    int snap;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #0.5;
    check(bus_valid == 1'b0, "R1", "bus_valid after reset", bus_valid, 0);
    check(fence_done == 1'b0, "R1", "fence_done after reset", fence_done, 0);
    check(st_ready == 1'b1, "R1", "st_ready after reset", st_ready, 1);

    // R2: global disable, each store narrow
    coal_off = 1'b1;
    push_narrow(32'h400, 32'hDEADBEEF, 4'hF, "R2");
    store(32'h400, 32'hDEADBEEF, 4'hF, 1'b1);
    push_narrow(32'h404, 32'h12345678, 4'h5, "R2");
    store(32'h404, 32'h12345678, 4'h5, 1'b1);
    idle();
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R2", "narrow stores delivered", q.size(), 0);
    coal_off = 1'b0;

    // R3: merge on but page denies
    push_narrow(32'h500, 32'hA5A5A5A5, 4'hF, "R3");
    store(32'h500, 32'hA5A5A5A5, 4'hF, 1'b0);
    push_narrow(32'h504, 32'h5A5A5A5A, 4'hF, "R3");
    store(32'h504, 32'h5A5A5A5A, 4'hF, 1'b0);
    idle();
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R3", "non-permitted stores delivered", q.size(), 0);

    // R5: full doubleword leaves without fence
    push_wide(32'h100, 64'h22222222_11111111, 8'hFF, "R5");
    store(32'h100, 32'h11111111, 4'hF, 1'b1);
    store(32'h104, 32'h22222222, 4'hF, 1'b1);
    idle();
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R5", "complete entry drained unprompted", q.size(), 0);

    // R4: partial merge with overwrite, flushed by fence
    store(32'h140, 32'h11223344, 4'h3, 1'b1);
    store(32'h144, 32'hAABBCCDD, 4'hC, 1'b1);
    store(32'h140, 32'h000000EE, 4'h1, 1'b1);
    idle();
    repeat (4) @(negedge clk);
    check(q.size() == 0 && bus_valid == 1'b0, "R4", "partial entry held", bus_valid, 0);
    push_wide(32'h140, 64'hAABB0000_000033EE, 8'hC3, "R4");
    fence(1'b0, 0, 0, 0, w);

    // R6: non-mergeable store waits for older entry
    push_wide(32'h300, 64'h00000000_00005678, 8'h03, "R6");
    push_narrow(32'h308, 32'hCAFEF00D, 4'hF, "R6");
    store(32'h300, 32'h12345678, 4'h3, 1'b1);
    store(32'h308, 32'hCAFEF00D, 4'hF, 1'b0);
    idle();
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R6", "ordered drain then narrow", q.size(), 0);

    // R7: occupancy pressure drains lowest entry first
    push_wide(32'h200, 64'h00000000_000000A0, 8'h01, "R7");
    push_wide(32'h220, 64'h00000000_000000E0, 8'h01, "R7");
    push_wide(32'h208, 64'h00000000_000000B0, 8'h01, "R7");
    push_wide(32'h210, 64'h00000000_000000C0, 8'h01, "R7");
    push_wide(32'h218, 64'h00000000_000000D0, 8'h01, "R7");
    store(32'h200, 32'h000000A0, 4'h1, 1'b1);
    store(32'h208, 32'h000000B0, 4'h1, 1'b1);
    store(32'h210, 32'h000000C0, 4'h1, 1'b1);
    store(32'h218, 32'h000000D0, 4'h1, 1'b1);
    store(32'h220, 32'h000000E0, 4'h1, 1'b1);
    idle();
    fence(1'b0, 0, 0, 0, w);

    // R8: store in the same cycle as the fence request
    push_wide(32'h600, 64'h00000000_13579BDF, 8'h0F, "R8");
    fence(1'b1, 32'h600, 32'h13579BDF, 4'hF, w);

    // R9: fence on empty block
    fence(1'b0, 0, 0, 0, w);
    check(w == 2, "R9", "fence_done latency on empty block", w, 2);

    // R10: repeated request while pending
    push_wide(32'h700, 64'h00000000_00000077, 8'h01, "R10");
    store(32'h700, 32'h00000077, 4'h1, 1'b1);
    idle();
    snap = done_cnt;
    @(negedge clk); fence_req = 1'b1;
    @(negedge clk);
    @(negedge clk); fence_req = 1'b0;
    repeat (20) @(negedge clk);
    check(done_cnt - snap == 1, "R10", "single fence_done pulse", done_cnt - snap, 1);

    // R11: bus backpressure
    bp_mode = 1'b1;
    coal_off = 1'b1;
    for (int k = 0; k < 3; k++) begin
      push_narrow(32'h800 + 4 * k, 32'h0B0B0000 + k, 4'hF, "R11");
      store(32'h800 + 4 * k, 32'h0B0B0000 + k, 4'hF, 1'b1);
    end
    idle();
    repeat (10) @(negedge clk);
    coal_off = 1'b0;
    push_wide(32'h900, 64'h99999999_88888888, 8'hFF, "R11");
    store(32'h900, 32'h88888888, 4'hF, 1'b1);
    store(32'h904, 32'h99999999, 4'hF, 1'b1);
    idle();
    repeat (40) @(negedge clk);
    check(q.size() == 0, "R11", "all transactions delivered under backpressure", q.size(), 0);
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule